// File: doc/BRIEF.md
# Upstream Packet Aggregator

This block takes a byte stream that a device sends toward the host and cuts it into USB-sized packets for an IN endpoint. A packet closes when it reaches the selected size, or earlier when the source marks the end of a transfer. Closed packets are written into a shared byte buffer. Each stored byte carries a flag that marks the final byte of its packet.

In stream mode, closed packets stay in the buffer until a batch is ready. A batch is ready when a programmed number of packets has closed, or when an idle timer expires. The timer counts in steps of 32 clocks and restarts whenever a packet closes. A full buffer also releases the batch. In packed mode, every packet is released as soon as it closes. An enable bit gates the input side. Released packets leave one byte per beat on a valid/ready port, with a last-beat flag.

Top module: `usb_up_aggregator`

## Requirements
- R1: With `cfg_hs_size` = 0, packets are SMALL_PKT bytes long (64 by default). With `cfg_hs_size` = 1, they are BIG_PKT bytes long (512 by default). `out_last` is 1 on the final byte of every packet and 0 on every other byte.
- R2: An accepted byte with `in_eot` = 1 closes the current packet. That byte is the packet's last byte, even if the packet is shorter than the selected size.
- R3: In stream mode (`cfg_packed` = 0), closed packets are held until `cfg_agg_num` + 1 of them are waiting. They are then released together. A value of 0 releases each packet on its own.
- R4: When `cfg_tmo` = T ≠ 0 and packets are held, they are all released once T·32 clocks pass without a new packet closing. The release reaches the output about 66 clocks after the last close for T = 2, and not before 60. With T = 0 the timer never releases.
- R5: In packed mode (`cfg_packed` = 1), each closed packet is released within two clocks, whatever `cfg_agg_num` is.
- R6: While `cfg_dma_en` = 0, `in_ready` is 0 and no input byte is taken. Packets already held can still be released and drained.
- R7: While the buffer holds DEPTH bytes, `in_ready` is 0. A full buffer releases all held packets, even when the count and the timer have not been reached.
- R8: Output bytes leave in input order with none lost or duplicated. `out_data` and `out_last` stay stable while `out_valid` = 1 and `out_ready` = 0.
- R9: After reset, `out_valid` is 0, the buffer is empty, and `in_ready` equals `cfg_dma_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | Enables input acceptance |
| cfg_packed | input | 1 | 0 = stream mode (batched), 1 = packed mode (immediate release) |
| cfg_hs_size | input | 1 | 0 = SMALL_PKT packet size, 1 = BIG_PKT packet size |
| cfg_agg_num | input | AGG_W | Batch size minus one |
| cfg_tmo | input | TMO_W | Idle timeout in 32-clock units; 0 disables the timeout |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken on this clock |
| in_data | input | DW | Input byte |
| in_eot | input | 1 | End of transfer; closes the packet on this byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | DW | Output byte |
| out_last | output | 1 | Final byte of a packet |

## Verification
The assertions assume that the packet-size bit does not change while a packet is partly assembled. They also assume that the batch size is not lowered below the number of packets already held, and that packed mode is not switched on while more than one packet is waiting.

The bench changes the size and mode fields only when the buffer is empty. While packets are held, it changes the batch size only from 1 to 0 with one packet waiting, and it only raises the timeout. Backpressure comes from a pseudo-random ready pattern, which exercises the output stability property.

// File: rtl/agg_pkg.sv
package agg_pkg;
  // timeout unit is 2**TICK_BITS clocks
  localparam int unsigned TICK_BITS = 5;

  typedef enum logic {
    SZ_FULL = 1'b0,
    SZ_HIGH = 1'b1
  } pkt_size_e;

  function automatic int unsigned pick_size(pkt_size_e sel, int unsigned small_b,
                                            int unsigned big_b);
    return (sel == SZ_HIGH) ? big_b : small_b;
  endfunction
endpackage

// File: rtl/agg_pktz.sv
module agg_pktz #(
  parameter int unsigned SMALL_PKT = 64,
  parameter int unsigned BIG_PKT   = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  agg_pkg::pkt_size_e size_sel,
  input  logic              beat,
  input  logic              eot,
  output logic              close
);
  localparam int unsigned CNT_W = $clog2(BIG_PKT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim   = CNT_W'(agg_pkg::pick_size(size_sel, SMALL_PKT, BIG_PKT) - 1);
  assign close = beat && (eot || (cnt == lim));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (beat) begin
      cnt <= close ? '0 : cnt + 1'b1;
    end
  end

  // R1
  pkt_len_chk: assert property (@(posedge clk) disable iff (rst) cnt <= lim);
endmodule

// File: rtl/agg_flush.sv
module agg_flush #(
  parameter int unsigned AGG_W = 4,
  parameter int unsigned TMO_W = 8,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_done,
  input  logic             packed_mode,
  input  logic [AGG_W-1:0] agg_num,
  input  logic [TMO_W-1:0] tmo,
  input  logic             buf_full,
  output logic             flush,
  output logic [CNT_W-1:0] flush_cnt
);
  localparam int unsigned CMP_W = (CNT_W > AGG_W) ? CNT_W : AGG_W;
  localparam int unsigned PRE_W = agg_pkg::TICK_BITS;

  logic [CNT_W-1:0] held;
  logic [PRE_W-1:0] pre;
  logic [TMO_W-1:0] units;
  logic             expired;
  logic             count_hit;

  assign expired   = (tmo != '0) && (units >= tmo);
  assign count_hit = CMP_W'(held) > CMP_W'(agg_num);
  assign flush     = (held != '0) && (packed_mode || count_hit || expired || buf_full);
  assign flush_cnt = held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (flush) begin
      held <= CNT_W'(pkt_done);
    end else begin
      held <= held + CNT_W'(pkt_done);
    end
  end

  // idle timer: runs only while packets wait, restarts on every close
  always_ff @(posedge clk) begin
    if (rst || pkt_done || flush || (held == '0)) begin
      pre   <= '0;
      units <= '0;
    end else begin
      pre <= pre + 1'b1;
      if ((pre == '1) && (units != '1)) begin
        units <= units + 1'b1;
      end
    end
  end

  // R3
  held_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (CMP_W + 1)'(held) <= (CMP_W + 1)'(agg_num) + (CMP_W + 1)'(1));
  // R5
  packed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    packed_mode |-> (held <= CNT_W'(1)));
  // R4
  tmo_rel_chk: assert property (@(posedge clk) disable iff (rst)
    ((held != '0) && expired) |=> (held <= CNT_W'(1)));
endmodule

// File: rtl/agg_buf.sv
module agg_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          full,
  input  logic          rel_en,
  input  logic [CW-1:0] rel_add,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] fill;
  logic [CW-1:0] rel;
  logic [DW:0]   rd_word;
  logic          pop;

  assign rd_word = mem[rd_ptr];
  assign pop     = (rel != '0) && (!out_valid || out_ready);
  assign full    = (fill == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr] <= {wr_last, wr_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      rel    <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      fill <= fill + CW'(wr_en) - CW'(pop);
      rel  <= rel + (rel_en ? rel_add : '0) - CW'(pop && rd_word[DW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_data  <= rd_word[DW-1:0];
      out_last  <= rd_word[DW];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst) fill <= CW'(DEPTH));
  // R7
  no_write_full_chk: assert property (@(posedge clk) disable iff (rst) full |-> !wr_en);
  // R8
  rel_backed_chk: assert property (@(posedge clk) disable iff (rst) (rel != '0) |-> (fill != '0));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/usb_up_aggregator.sv
module usb_up_aggregator #(
  parameter int unsigned DW        = 8,
  parameter int unsigned SMALL_PKT = 64,
  parameter int unsigned BIG_PKT   = 512,
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned AGG_W     = 4,
  parameter int unsigned TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_dma_en,
  input  logic             cfg_packed,
  input  logic             cfg_hs_size,
  input  logic [AGG_W-1:0] cfg_agg_num,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_eot,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          full;
  logic          beat;
  logic          close;
  logic          flush;
  logic [CW-1:0] flush_cnt;

  assign in_ready = cfg_dma_en && !full;
  assign beat     = in_valid && in_ready;

  agg_pktz #(
    .SMALL_PKT(SMALL_PKT),
    .BIG_PKT  (BIG_PKT)
  ) u_pktz (
    .clk     (clk),
    .rst     (rst),
    .size_sel(agg_pkg::pkt_size_e'(cfg_hs_size)),
    .beat    (beat),
    .eot     (in_eot),
    .close   (close)
  );

  agg_flush #(
    .AGG_W(AGG_W),
    .TMO_W(TMO_W),
    .CNT_W(CW)
  ) u_flush (
    .clk        (clk),
    .rst        (rst),
    .pkt_done   (close),
    .packed_mode(cfg_packed),
    .agg_num    (cfg_agg_num),
    .tmo        (cfg_tmo),
    .buf_full   (full),
    .flush      (flush),
    .flush_cnt  (flush_cnt)
  );

  agg_buf #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .CW   (CW)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (beat),
    .wr_data  (in_data),
    .wr_last  (close),
    .full     (full),
    .rel_en   (flush),
    .rel_add  (flush_cnt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
  );

  // R6
  dis_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_dma_en |-> !beat);
endmodule

// File: tb/usb_up_aggregator_bench.sv
module usb_up_aggregator_bench;
  localparam int DW = 8, SP = 4, BP = 8, DEP = 32, AGW = 4, TMW = 8;

  typedef struct packed {
    logic       hs;
    logic       pk;
    logic [3:0] agg;
    logic [7:0] tmo;
    logic [7:0] n;
    logic       eot;
    logic [3:0] pkts;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 4'd0, 8'd0, 8'd16, 1'b0, 4'd4},
    '{1'b1, 1'b0, 4'd1, 8'd0, 8'd16, 1'b0, 4'd2},
    '{1'b0, 1'b0, 4'd3, 8'd0, 8'd16, 1'b0, 4'd4},
    '{1'b0, 1'b1, 4'd5, 8'd0, 8'd10, 1'b1, 4'd3},
    '{1'b1, 1'b0, 4'd0, 8'd0, 8'd13, 1'b1, 4'd2},
    '{1'b0, 1'b0, 4'd2, 8'd3, 8'd7,  1'b1, 4'd2}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           cfg_dma_en = 1'b1, cfg_packed = 1'b0, cfg_hs_size = 1'b0;
  logic [AGW-1:0] cfg_agg_num = '0;
  logic [TMW-1:0] cfg_tmo = '0;
  logic           in_valid = 1'b0, in_eot = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic           in_ready, out_valid, out_last;
  logic [DW-1:0]  out_data;
  logic           out_ready = 1'b1;

  usb_up_aggregator #(
    .DW(DW), .SMALL_PKT(SP), .BIG_PKT(BP), .DEPTH(DEP), .AGG_W(AGW), .TMO_W(TMW)
  ) u_usb_up_aggregator (
    .clk(clk), .rst(rst), .cfg_dma_en(cfg_dma_en), .cfg_packed(cfg_packed),
    .cfg_hs_size(cfg_hs_size), .cfg_agg_num(cfg_agg_num), .cfg_tmo(cfg_tmo),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eot(in_eot),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, fails = 0, cyc = 0, rx_n = 0, ready_mode = 0, base = 0;
  logic [DW-1:0] rx_d [0:1023];
  logic          rx_l [0:1023];
  logic [7:0]    lfsr = 8'h5a;

  // output collector, ready pattern and watchdog
  always @(negedge clk) begin
    cyc = cyc + 1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = lfsr[0];
      default: out_ready = 1'b0;
    endcase
    if (!rst && out_valid && out_ready) begin
      rx_d[rx_n & 1023] = out_data;
      rx_l[rx_n & 1023] = out_last;
      rx_n = rx_n + 1;
    end
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL R8 watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act,
                     input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic hs, input logic pk, input int agg, input int tmo);
    cfg_hs_size = hs;
    cfg_packed  = pk;
    cfg_agg_num = AGW'(agg);
    cfg_tmo     = TMW'(tmo);
  endtask

  task automatic send(input int n, input bit eot_end, input int b);
    int i = 0;
    int stall = 0;
    while (i < n && stall < 5000) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(b + i);
      in_eot   = eot_end && (i == n - 1);
      if (in_ready) i = i + 1;
      else stall = stall + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eot   = 1'b0;
  endtask

  task automatic wait_rx(input int target, input int limit);
    int k = 0;
    while (rx_n < target && k < limit) begin
      @(negedge clk);
      k = k + 1;
    end
  endtask

  task automatic verify(input int start, input int n, input int size, input bit eot_end,
                        input int b, input string req, input int exp_pkts);
    int lasts = 0;
    chk(rx_n - start == n, req, "byte count", rx_n - start, n);
    for (int j = 0; j < n; j++) begin
      bit exp_l = ((j + 1) % size == 0) || (eot_end && j == n - 1);
      chk(rx_d[(start + j) & 1023] == DW'(b + j), req, "data",
          int'(rx_d[(start + j) & 1023]), int'(DW'(b + j)));
      chk(rx_l[(start + j) & 1023] == exp_l, req, "last flag",
          int'(rx_l[(start + j) & 1023]), int'(exp_l));
      if (rx_l[(start + j) & 1023]) lasts = lasts + 1;
    end
    chk(lasts == exp_pkts, req, "packet count", lasts, exp_pkts);
  endtask

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R3 agg0";
      1: return "R1 big size";
      2: return "R3 batch";
      3: return "R5 packed";
      4: return "R2 short eot";
      default: return "R4 timeout";
    endcase
  endfunction

  initial begin
    int start;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

    // vector table, alternating free-running and random backpressure (R8)
    for (int v = 0; v < 6; v++) begin
      set_cfg(VEC[v].hs, VEC[v].pk, int'(VEC[v].agg), int'(VEC[v].tmo));
      ready_mode = v % 2;
      start = rx_n;
      send(int'(VEC[v].n), VEC[v].eot, base);
      wait_rx(start + int'(VEC[v].n), 2000);
      verify(start, int'(VEC[v].n), VEC[v].hs ? BP : SP, VEC[v].eot, base, vec_tag(v),
             int'(VEC[v].pkts));
      base = base + int'(VEC[v].n);
    end
    ready_mode = 0;

    // R3: two of three packets are held
    set_cfg(1'b0, 1'b0, 2, 0);
    start = rx_n;
    send(8, 1'b0, base);
    repeat (100) @(negedge clk);
    chk(rx_n == start, "R3", "bytes before batch full", rx_n - start, 0);
    send(4, 1'b0, base + 8);
    wait_rx(start + 12, 200);
    verify(start, 12, SP, 1'b0, base, "R3", 3);
    base = base + 12;

    // R4: timeout of 2 units, release at about 66 clocks
    set_cfg(1'b0, 1'b0, 7, 2);
    start = rx_n;
    send(4, 1'b0, base);
    repeat (59) @(negedge clk);
    chk(rx_n == start, "R4", "bytes before timeout", rx_n - start, 0);
    repeat (21) @(negedge clk);
    verify(start, 4, SP, 1'b0, base, "R4", 1);
    base = base + 4;

    // R4: zero timeout never releases
    set_cfg(1'b0, 1'b0, 7, 0);
    start = rx_n;
    send(4, 1'b0, base);
    repeat (300) @(negedge clk);
    chk(rx_n == start, "R4", "bytes with timeout off", rx_n - start, 0);
    cfg_tmo = TMW'(1);
    wait_rx(start + 4, 200);
    verify(start, 4, SP, 1'b0, base, "R4", 1);
    base = base + 4;

    // R5: packed mode releases at once
    set_cfg(1'b0, 1'b1, 15, 0);
    start = rx_n;
    send(4, 1'b0, base);
    repeat (6) @(negedge clk);
    verify(start, 4, SP, 1'b0, base, "R5", 1);
    base = base + 4;

    // R6: disabled input takes nothing, held data still drains
    set_cfg(1'b0, 1'b0, 1, 0);
    start = rx_n;
    send(4, 1'b0, base);
    cfg_dma_en = 1'b0;
    begin
      int taken = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hEE;
        if (in_ready) taken = taken + 1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(taken == 0, "R6", "in_ready while disabled", taken, 0);
    end
    cfg_agg_num = '0;
    wait_rx(start + 4, 200);
    verify(start, 4, SP, 1'b0, base, "R6", 1);
    base = base + 4;
    cfg_dma_en = 1'b1;
    start = rx_n;
    send(4, 1'b0, base);
    wait_rx(start + 4, 200);
    verify(start, 4, SP, 1'b0, base, "R6", 1);
    base = base + 4;

    // R7: full buffer stalls input and forces a release
    set_cfg(1'b1, 1'b0, 15, 0);
    ready_mode = 2;
    start = rx_n;
    send(DEP, 1'b0, base);
    chk(in_ready == 1'b0, "R7", "in_ready when full", int'(in_ready), 0);
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b1, "R7", "release on full", int'(out_valid), 1);
    ready_mode = 0;
    wait_rx(start + DEP, 500);
    verify(start, DEP, BP, 1'b0, base, "R7", DEP / BP);
    base = base + DEP;

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule